// File: doc/BRIEF.md
# FP16 Normalized Mantissa Extraction Unit

This block takes a packed vector of IEEE half-precision values and rescales each value's significand into one of four intervals. The exponent of the result is picked from a small set: the bias, or the bias minus one. The choice depends on the selected interval, the parity of the source's unbiased exponent, or the top bit of its fraction. A sign-control field either keeps the source sign or forces a positive result. It can also turn any negative input into the default quiet NaN. Zeros, infinities, NaNs and subnormals follow fixed rules. Subnormals are first normalised by shifting the fraction up to its leading one.

Each lane is computed combinationally and then registered once. Each lane has a writemask bit, and masking can be turned off. A lane that is off either keeps a supplied old value (merge) or goes to zero (zeroing). A broadcast option feeds element 0 to every lane. Two status flags are returned with the result: invalid and denormal. Each one is the OR over the active lanes only.

Top module: `fp16_mant_unit`

## Requirements
- R1: With control bits [1:0] = 00, a finite nonzero result has exponent field 15. With control bits [1:0] = 10, it has exponent field 14. In both cases the fraction field (bits [9:0]) is the input fraction, after normalisation for subnormals.
- R2: With control bits [1:0] = 01, the exponent field is 14 when the unbiased source exponent (field minus 15) is odd, and 15 when it is even.
- R3: With control bits [1:0] = 11, the exponent field is 14 when fraction bit 9 is 1, and 15 when it is 0.
- R4: When control bit 2 is 1, the sign bit (bit 15) of every non-NaN result is 0. When control bit 2 is 0, the result keeps the source sign.
- R5: A NaN input (exponent field 0x1F, nonzero fraction) returns the source with fraction bit 9 set. This takes precedence over every other rule. The invalid flag is raised when source fraction bit 9 was 0.
- R6: +0 and +inf give 0x3C00 for any interval. -0 gives 0x3C00 when control bit 2 is 1 and 0xBC00 when it is 0, whatever control bit 3 is. -inf with control bit 3 = 0 follows the same rule as -0.
- R7: When control bit 3 is 1, every negative non-NaN input other than -0 returns 0xFE00 and raises the invalid flag. This includes -inf.
- R8: A subnormal input that reaches the interval rules is normalised first. Its fraction is shifted left until a 1 leaves bit 9, the exponent starts at 15 and drops by one per shift, and the denormal flag is raised.
- R9: An active lane (mask bit 1, or masking disabled) takes its own element, or element 0 when broadcast is set. An inactive lane outputs 0 in zeroing mode and the old-vector lane in merge mode.
- R10: The invalid and denormal flags are ORed over active lanes only. They are 0 when no lane is active.
- R11: Control bits [7:4] have no effect on results or flags.
- R12: Result, flags and outValid appear one clock after inValid. Result and flags hold while inValid is 0. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Inputs are valid this cycle |
| srcVec | input | VEC_W | Packed half-precision source lanes, lane 0 in bits [15:0] |
| oldVec | input | VEC_W | Old destination lanes used by merge masking |
| laneMask | input | VEC_W/16 | Per-lane write enable |
| maskEnable | input | 1 | 1 applies laneMask, 0 makes every lane active |
| zeroMode | input | 1 | 1 zeroes inactive lanes, 0 merges old values |
| bcast | input | 1 | Feed lane 0 of srcVec to every lane |
| ctrlByte | input | 8 | [1:0] interval select, [3:2] sign control, [7:4] ignored |
| outValid | output | 1 | Result valid |
| resVec | output | VEC_W | Packed results |
| flagInvalid | output | 1 | Invalid status over active lanes |
| flagDenorm | output | 1 | Denormal status over active lanes |

## Verification
Each lane is rebuilt every cycle from the ports, and the only state is one output register stage. A wrong decision therefore shows on resVec one clock after the offending input, and does not carry into later operations. Possible wrong decisions include a mis-decoded interval, a wrong leading-one count, or a mask gate on the wrong lane. A fault in the valid or load path shows in two ways: outValid out of step with inValid, or resVec changing during an idle cycle. Both are seen in that same next cycle. A flag gated on the wrong lanes shows as a status bit raised by an operation whose active lanes are all clean.

// File: rtl/fp16_mant_pkg.sv
package fp16_mant_pkg;
  localparam int HALF_W = 16;
  localparam int EXP_W  = 5;
  localparam int FRAC_W = 10;
  localparam int SHIFT_W = $clog2(FRAC_W + 1);

  localparam logic [EXP_W-1:0]  EXP_BIAS  = 5'd15;
  localparam logic [EXP_W-1:0]  EXP_MAX   = 5'h1F;
  localparam logic [HALF_W-1:0] DEF_QNAN  = 16'hFE00;
  localparam logic [HALF_W-1:0] POS_ONE   = 16'h3C00;
  localparam logic [HALF_W-1:0] NEG_ONE   = 16'hBC00;

  typedef enum logic [1:0] {
    IV_ONE_TWO   = 2'b00,
    IV_HALF_TWO  = 2'b01,
    IV_HALF_ONE  = 2'b10,
    IV_3Q_3H     = 2'b11
  } interv_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;
    interv_e interv;
    logic    forcePos;
    logic    negToNan;
    logic    bcast;
  } mantStrobe_t;
endpackage

// File: rtl/fp16_mant_lane.sv
module fp16_mant_lane
  import fp16_mant_pkg::*;
(
  input  logic [HALF_W-1:0] halfIn,
  input  interv_e           interv,
  input  logic              forcePos,
  input  logic              negToNan,
  output logic [HALF_W-1:0] halfOut,
  output logic              invRaised,
  output logic              denRaised
);
  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic isZero, isSub, isInf, isNan;
  logic [SHIFT_W-1:0] shiftCnt;
  logic [FRAC_W-1:0]  adjFrac;
  logic [EXP_W-1:0]   adjExp, outExp;
  logic               oddExp;
  logic [HALF_W-1:0]  signedOne;

  assign sgn = halfIn[HALF_W-1];
  assign ex  = halfIn[HALF_W-2 -: EXP_W];
  assign fr  = halfIn[FRAC_W-1:0];

  assign isZero = (ex == '0) && (fr == '0);
  assign isSub  = (ex == '0) && (fr != '0);
  assign isInf  = (ex == EXP_MAX) && (fr == '0);
  assign isNan  = (ex == EXP_MAX) && (fr != '0);
  assign signedOne = forcePos ? POS_ONE : NEG_ONE;

  // leading-one search: count of left shifts until a one leaves the top bit
  always_comb begin
    shiftCnt = '0;
    for (int i = 0; i < FRAC_W; i++) begin
      if (fr[i]) shiftCnt = SHIFT_W'(FRAC_W - i);
    end
  end

  always_comb begin
    adjFrac = isSub ? (fr << shiftCnt) : fr;
    adjExp  = isSub ? (EXP_BIAS - EXP_W'(shiftCnt)) : ex;
    oddExp  = ~adjExp[0];  // parity of (adjExp - 15)
    unique case (interv)
      IV_ONE_TWO:  outExp = EXP_BIAS;
      IV_HALF_TWO: outExp = oddExp ? EXP_BIAS - 5'd1 : EXP_BIAS;
      IV_HALF_ONE: outExp = EXP_BIAS - 5'd1;
      IV_3Q_3H:    outExp = adjFrac[FRAC_W-1] ? EXP_BIAS - 5'd1 : EXP_BIAS;
      default:     outExp = EXP_BIAS;
    endcase
  end

  always_comb begin
    invRaised = 1'b0;
    denRaised = 1'b0;
    if (isNan) begin
      halfOut   = halfIn | HALF_W'(1 << (FRAC_W - 1));
      invRaised = ~fr[FRAC_W-1];
    end else if (!sgn && (isZero || isInf)) begin
      halfOut = POS_ONE;
    end else if (sgn && isZero) begin
      halfOut = signedOne;
    end else if (sgn && isInf) begin
      halfOut   = negToNan ? DEF_QNAN : signedOne;
      invRaised = negToNan;
    end else if (sgn && negToNan) begin
      halfOut   = DEF_QNAN;
      invRaised = 1'b1;
    end else begin
      halfOut   = {(forcePos ? 1'b0 : sgn), outExp, adjFrac};
      denRaised = isSub;
    end
  end
endmodule

// File: rtl/fp16_mant_ctrl.sv
module fp16_mant_ctrl
  import fp16_mant_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [LANES-1:0] laneMask,
  input  logic             maskEnable,
  input  logic             zeroMode,
  input  logic             bcast,
  input  logic [7:0]       ctrlByte,
  output mantStrobe_t      strobe,
  output logic [LANES-1:0] laneActive,
  output logic [LANES-1:0] laneClear,
  output logic             outValid
);
  logic unusedHighBits;
  assign unusedHighBits = ^ctrlByte[7:4];

  assign strobe.load     = inValid;
  assign strobe.interv   = interv_e'(ctrlByte[1:0]);
  assign strobe.forcePos = ctrlByte[2];
  assign strobe.negToNan = ctrlByte[3];
  assign strobe.bcast    = bcast;

  assign laneActive = maskEnable ? laneMask : {LANES{1'b1}};
  assign laneClear  = ~laneActive & {LANES{zeroMode}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end
endmodule

// File: rtl/fp16_mant_dp.sv
module fp16_mant_dp
  import fp16_mant_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  mantStrobe_t             strobe,
  input  logic [LANES-1:0]        laneActive,
  input  logic [LANES-1:0]        laneClear,
  input  logic [LANES*HALF_W-1:0] srcVec,
  input  logic [LANES*HALF_W-1:0] oldVec,
  output logic [LANES*HALF_W-1:0] resVec,
  output logic                    flagInvalid,
  output logic                    flagDenorm
);
  logic [LANES*HALF_W-1:0] nextVec;
  logic [LANES-1:0]        laneInv, laneDen;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [HALF_W-1:0] laneIn, laneOut;
    assign laneIn = strobe.bcast ? srcVec[HALF_W-1:0] : srcVec[g*HALF_W +: HALF_W];
    fp16_mant_lane u_lane (
      .halfIn    (laneIn),
      .interv    (strobe.interv),
      .forcePos  (strobe.forcePos),
      .negToNan  (strobe.negToNan),
      .halfOut   (laneOut),
      .invRaised (laneInv[g]),
      .denRaised (laneDen[g])
    );
    assign nextVec[g*HALF_W +: HALF_W] =
      laneActive[g] ? laneOut :
      laneClear[g]  ? '0      : oldVec[g*HALF_W +: HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resVec      <= '0;
      flagInvalid <= 1'b0;
      flagDenorm  <= 1'b0;
    end else if (strobe.load) begin
      resVec      <= nextVec;
      flagInvalid <= |(laneInv & laneActive);
      flagDenorm  <= |(laneDen & laneActive);
    end
  end
endmodule

// File: rtl/fp16_mant_unit.sv
module fp16_mant_unit
  import fp16_mant_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inValid,
  input  logic [VEC_W-1:0]       srcVec,
  input  logic [VEC_W-1:0]       oldVec,
  input  logic [VEC_W/16-1:0]    laneMask,
  input  logic                   maskEnable,
  input  logic                   zeroMode,
  input  logic                   bcast,
  input  logic [7:0]             ctrlByte,
  output logic                   outValid,
  output logic [VEC_W-1:0]       resVec,
  output logic                   flagInvalid,
  output logic                   flagDenorm
);
  localparam int LANES = VEC_W / HALF_W;

  mantStrobe_t      strobe;
  logic [LANES-1:0] laneActive, laneClear;

  fp16_mant_ctrl #(.LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .inValid    (inValid),
    .laneMask   (laneMask),
    .maskEnable (maskEnable),
    .zeroMode   (zeroMode),
    .bcast      (bcast),
    .ctrlByte   (ctrlByte),
    .strobe     (strobe),
    .laneActive (laneActive),
    .laneClear  (laneClear),
    .outValid   (outValid)
  );

  fp16_mant_dp #(.LANES(LANES)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .laneActive  (laneActive),
    .laneClear   (laneClear),
    .srcVec      (srcVec),
    .oldVec      (oldVec),
    .resVec      (resVec),
    .flagInvalid (flagInvalid),
    .flagDenorm  (flagDenorm)
  );
endmodule

// File: rtl/fp16_mant_chk.sv
module fp16_mant_chk #(
  parameter int VEC_W = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inValid,
  input logic [VEC_W-1:0]    srcVec,
  input logic [VEC_W-1:0]    oldVec,
  input logic [VEC_W/16-1:0] laneMask,
  input logic                maskEnable,
  input logic                zeroMode,
  input logic                bcast,
  input logic [7:0]          ctrlByte,
  input logic                outValid,
  input logic [VEC_W-1:0]    resVec,
  input logic                flagInvalid,
  input logic                flagDenorm
);
  localparam int LANES = VEC_W / 16;

  logic lane0Nan, lane0NegFin, plainLane0;
  assign lane0Nan    = (srcVec[14:10] == 5'h1F) && (srcVec[9:0] != '0);
  assign lane0NegFin = srcVec[15] && !lane0Nan && (srcVec[14:0] != '0);
  assign plainLane0  = inValid && !bcast && (!maskEnable || laneMask[0]);

  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  // R12
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid && $stable(resVec) && $stable(flagInvalid) && $stable(flagDenorm));
  // R10
  no_active_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && maskEnable && (laneMask == '0) |=> !flagInvalid && !flagDenorm);
  // R5
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plainLane0 && lane0Nan |=> resVec[15:0] == ($past(srcVec[15:0]) | 16'h0200));
  // R7
  neg_to_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plainLane0 && ctrlByte[3] && lane0NegFin |=> resVec[15:0] == 16'hFE00 && flagInvalid);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R9
    zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inValid && maskEnable && zeroMode && !laneMask[g] |=> resVec[g*16 +: 16] == '0);
    // R9
    merge_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inValid && maskEnable && !zeroMode && !laneMask[g]
      |=> resVec[g*16 +: 16] == $past(oldVec[g*16 +: 16]));
  end
endmodule

bind fp16_mant_unit fp16_mant_chk #(.VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .inValid     (inValid),
  .srcVec      (srcVec),
  .oldVec      (oldVec),
  .laneMask    (laneMask),
  .maskEnable  (maskEnable),
  .zeroMode    (zeroMode),
  .bcast       (bcast),
  .ctrlByte    (ctrlByte),
  .outValid    (outValid),
  .resVec      (resVec),
  .flagInvalid (flagInvalid),
  .flagDenorm  (flagDenorm)
);

// File: tb/fp16_mant_unit_bench.sv
module fp16_mant_unit_bench;
  localparam int VEC_W = 128;
  localparam int LANES = VEC_W / 16;
  localparam int NVEC  = 34;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                inValid = 1'b0;
  logic [VEC_W-1:0]    srcVec = '0;
  logic [VEC_W-1:0]    oldVec = '0;
  logic [LANES-1:0]    laneMask = '0;
  logic                maskEnable = 1'b0;
  logic                zeroMode = 1'b0;
  logic                bcast = 1'b0;
  logic [7:0]          ctrlByte = '0;
  logic                outValid;
  logic [VEC_W-1:0]    resVec;
  logic                flagInvalid, flagDenorm;

  int nChecks = 0;
  int nErrors = 0;

  always #5 clk = ~clk;

  fp16_mant_unit #(.VEC_W(VEC_W)) u_fp16_mant_unit (
    .clk, .rst_n, .inValid, .srcVec, .oldVec, .laneMask, .maskEnable,
    .zeroMode, .bcast, .ctrlByte, .outValid, .resVec, .flagInvalid, .flagDenorm
  );

  // {src, ctrl, expected, invalid, denormal, requirement}
  localparam logic [45:0] TBL [NVEC] = '{
    {16'h3C00, 8'h00, 16'h3C00, 1'b0, 1'b0, 4'd1},  // R1
    {16'h3C00, 8'h02, 16'h3800, 1'b0, 1'b0, 4'd1},  // R1
    {16'h4A00, 8'h00, 16'h3E00, 1'b0, 1'b0, 4'd1},  // R1
    {16'h4A00, 8'h02, 16'h3A00, 1'b0, 1'b0, 4'd1},  // R1
    {16'h4000, 8'h01, 16'h3800, 1'b0, 1'b0, 4'd2},  // R2 odd
    {16'h3C00, 8'h01, 16'h3C00, 1'b0, 1'b0, 4'd2},  // R2 even
    {16'h4A00, 8'h01, 16'h3A00, 1'b0, 1'b0, 4'd2},  // R2
    {16'h4A00, 8'h03, 16'h3A00, 1'b0, 1'b0, 4'd3},  // R3
    {16'h4500, 8'h03, 16'h3D00, 1'b0, 1'b0, 4'd3},  // R3
    {16'hC500, 8'h00, 16'hBD00, 1'b0, 1'b0, 4'd4},  // R4
    {16'hC500, 8'h04, 16'h3D00, 1'b0, 1'b0, 4'd4},  // R4
    {16'hC500, 8'h08, 16'hFE00, 1'b1, 1'b0, 4'd7},  // R7
    {16'h8300, 8'h0C, 16'hFE00, 1'b1, 1'b0, 4'd7},  // R7
    {16'h7C01, 8'h00, 16'h7E01, 1'b1, 1'b0, 4'd5},  // R5
    {16'hFE05, 8'h00, 16'hFE05, 1'b0, 1'b0, 4'd5},  // R5
    {16'h7C01, 8'h04, 16'h7E01, 1'b1, 1'b0, 4'd5},  // R5
    {16'hFC01, 8'h0C, 16'hFE01, 1'b1, 1'b0, 4'd5},  // R5
    {16'h7C00, 8'h00, 16'h3C00, 1'b0, 1'b0, 4'd6},  // R6
    {16'h0000, 8'h02, 16'h3C00, 1'b0, 1'b0, 4'd6},  // R6
    {16'h8000, 8'h00, 16'hBC00, 1'b0, 1'b0, 4'd6},  // R6
    {16'h8000, 8'h08, 16'hBC00, 1'b0, 1'b0, 4'd6},  // R6
    {16'h8000, 8'h04, 16'h3C00, 1'b0, 1'b0, 4'd6},  // R6
    {16'hFC00, 8'h00, 16'hBC00, 1'b0, 1'b0, 4'd6},  // R6
    {16'hFC00, 8'h04, 16'h3C00, 1'b0, 1'b0, 4'd6},  // R6
    {16'hFC00, 8'h08, 16'hFE00, 1'b1, 1'b0, 4'd7},  // R7
    {16'h0001, 8'h00, 16'h3C00, 1'b0, 1'b1, 4'd8},  // R8
    {16'h0300, 8'h01, 16'h3A00, 1'b0, 1'b1, 4'd8},  // R8
    {16'h0300, 8'h00, 16'h3E00, 1'b0, 1'b1, 4'd8},  // R8
    {16'h8300, 8'h00, 16'hBE00, 1'b0, 1'b1, 4'd8},  // R8
    {16'h0300, 8'h03, 16'h3A00, 1'b0, 1'b1, 4'd8},  // R8
    {16'h0080, 8'h01, 16'h3800, 1'b0, 1'b1, 4'd8},  // R8
    {16'h8300, 8'h04, 16'h3E00, 1'b0, 1'b1, 4'd8},  // R8
    {16'h0300, 8'hF1, 16'h3A00, 1'b0, 1'b1, 4'd11}, // R11
    {16'hC500, 8'hF4, 16'h3D00, 1'b0, 1'b0, 4'd11}  // R11
  };

  task automatic check(input string tag, input logic [VEC_W-1:0] got, input logic [VEC_W-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // drive at negedge, load on next posedge, return at the following negedge
  task automatic step(input logic [VEC_W-1:0] src, input logic [VEC_W-1:0] old,
                      input logic [LANES-1:0] msk, input logic men, input logic zm,
                      input logic bc, input logic [7:0] ctl);
    srcVec = src; oldVec = old; laneMask = msk; maskEnable = men;
    zeroMode = zm; bcast = bc; ctrlByte = ctl; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    logic [VEC_W-1:0] oldPat, expV, held;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset outValid", VEC_W'(outValid), '0);
    check("R12 reset resVec", resVec, '0);
    check("R12 reset flags", VEC_W'({flagInvalid, flagDenorm}), '0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (TBL[k]) begin
      logic [15:0] s, e; logic [7:0] c; logic iv, dn; logic [3:0] rq;
      {s, c, e, iv, dn, rq} = TBL[k];
      step({LANES{s}}, '0, '0, 1'b0, 1'b0, 1'b0, c);
      check($sformatf("R%0d vec %0d result", rq, k), resVec, {LANES{e}});
      check($sformatf("R%0d vec %0d invalid", rq, k), VEC_W'(flagInvalid), VEC_W'(iv));
      check($sformatf("R%0d vec %0d denormal", rq, k), VEC_W'(flagDenorm), VEC_W'(dn));
    end

    for (int i = 0; i < LANES; i++) oldPat[i*16 +: 16] = 16'hA000 + 16'(i);

    // R9 merge: odd lanes inactive keep old values
    step({LANES{16'h4A00}}, oldPat, 8'h55, 1'b1, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < LANES; i++)
      expV[i*16 +: 16] = (i % 2 == 0) ? 16'h3E00 : oldPat[i*16 +: 16];
    check("R9 merge masking", resVec, expV);

    // R9 zeroing
    step({LANES{16'h4A00}}, oldPat, 8'h0F, 1'b1, 1'b1, 1'b0, 8'h00);
    for (int i = 0; i < LANES; i++)
      expV[i*16 +: 16] = (i < 4) ? 16'h3E00 : 16'h0000;
    check("R9 zero masking", resVec, expV);

    // R9 masking disabled: mask value ignored
    step({LANES{16'h4A00}}, oldPat, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R9 mask disabled", resVec, {LANES{16'h3E00}});

    // R9 broadcast of lane 0
    step({{(LANES-1){16'h7C01}}, 16'h4A00}, oldPat, '0, 1'b0, 1'b0, 1'b1, 8'h00);
    check("R9 broadcast result", resVec, {LANES{16'h3E00}});
    check("R9 broadcast no invalid", VEC_W'(flagInvalid), '0);

    // R10 flags only from active lanes
    expV = {LANES{16'h3C00}};
    expV[3*16 +: 16] = 16'h7C01;
    expV[4*16 +: 16] = 16'h0001;
    step(expV, oldPat, 8'hE7, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R10 masked-off flags", VEC_W'({flagInvalid, flagDenorm}), '0);
    step(expV, oldPat, 8'h08, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R10 active invalid lane", VEC_W'({flagInvalid, flagDenorm}), VEC_W'(2'b10));
    step(expV, oldPat, 8'h10, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R10 active denormal lane", VEC_W'({flagInvalid, flagDenorm}), VEC_W'(2'b01));
    step(expV, oldPat, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R10 no active lanes", VEC_W'({flagInvalid, flagDenorm}), '0);

    // R12 latency and hold
    step({LANES{16'h4000}}, '0, '0, 1'b0, 1'b0, 1'b0, 8'h01);
    check("R12 outValid after load", VEC_W'(outValid), VEC_W'(1));
    held = resVec;
    srcVec = {LANES{16'h7C01}};
    ctrlByte = 8'h02;
    @(negedge clk);
    check("R12 outValid idle", VEC_W'(outValid), '0);
    check("R12 result hold", resVec, held);
    check("R12 flags hold", VEC_W'({flagInvalid, flagDenorm}), '0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule